// File: doc/BRIEF.md
# Diskette Controller Host Register File

This block is the host-facing register set of a four-drive diskette controller on an 8-bit I/O port bus. It claims an aligned window of eight port addresses above a base port given as a parameter. Inside that window it serves three readable bytes: a subsystem status byte, the result type of the last operation and the result byte of the last operation. It also accepts three writes: the two halves of a 16-bit parameter-block address and a subsystem reset.

Writing the high address byte starts an operation. The block raises a one-cycle start strobe toward the command engine, and in that same cycle it presents the full assembled address. When the engine finishes, it pulses a completion input carrying a result type, an error byte and a ready-changed flag. The block stores these values and sets a completion interrupt flip-flop. The host clears that flip-flop by reading the result-type port.

Top module: `dskc_host_regs`

## Requirements
- R1: A read at offset 0 returns the status byte with this layout: bit 0 drive 0 ready, bit 1 drive 1 ready, bit 2 the interrupt flip-flop, bits 3 and 4 always 1 (controller present, double-density present), bit 5 drive 2 ready, bit 6 drive 3 ready, bit 7 always 0.
- R2: A port hits the block only when its address bits above bit 2 equal those of `BASE_PORT`. A read that does not hit returns 0x00, and a write that does not hit has no effect.
- R3: A write at offset 1 stores the low address byte. A write at offset 2 stores the high byte and raises `start` for that cycle. During that cycle `blk_addr` already equals {new high byte, stored low byte}, and it holds that value afterwards.
- R4: A read at offset 1 returns the 2-bit result type in bits 1:0, with bits 7:2 zero. At the following clock edge it clears the interrupt flip-flop, and with it status bit 2 and `irq_out`.
- R5: A `done` pulse captures `done_rtype`, `done_err` and `done_rdychg`, and sets the interrupt flip-flop. If `done` arrives in the same cycle as a result-type read, the flip-flop ends up set.
- R6: When the result type is 00 (completed), a read at offset 3 returns the stored error byte.
- R7: When the result type is 10 and the ready-changed flag is set, a read at offset 3 returns bit 7 drive 1 ready, bit 6 drive 0 ready, bit 5 drive 3 ready, bit 4 drive 2 ready, and bits 3:0 zero. For type 10 without the flag, and for the reserved types 01 and 11, the read returns the error byte.
- R8: A write at offset 7 pulses `soft_rst` for one cycle. It sets the result type to 00 and clears both the error byte and the ready-changed flag. It leaves the interrupt flip-flop unchanged. If `done` arrives in the same cycle, the reset wins.
- R9: Reads at offsets 2, 4, 5, 6 and 7 return 0x00. Writes at offsets 0 and 3 change no readable state.
- R10: After the hardware reset: `irq_out` is 0, `start` and `soft_rst` are 0, `blk_addr` is 0x0000, the result type is 00 and the error byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | Port address |
| io_rd | input | 1 | Read strobe (read data is valid in the same cycle) |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0x00 when no readable register is addressed |
| drv_rdy | input | 4 | Ready level of each drive |
| done | input | 1 | Completion pulse from the command engine |
| done_rtype | input | 2 | Result type delivered with `done` |
| done_err | input | 8 | Error flags delivered with `done` |
| done_rdychg | input | 1 | Ready-changed flag delivered with `done` |
| start | output | 1 | One-cycle start strobe to the command engine |
| blk_addr | output | 16 | Parameter-block address |
| irq_out | output | 1 | Completion interrupt flip-flop |
| soft_rst | output | 1 | One-cycle subsystem reset pulse |

## Verification
Some rules are checked by the assertions on every cycle:
- `start` only appears with a write whose data is already in the high address byte.
- Completion always sets the interrupt.
- A lone result-type read always clears it.
- Status bit 2 mirrors `irq_out`, and status bit 7 is always 0.
- A missed address always reads zero.
- A subsystem reset clears the stored result and leaves the interrupt alone.

Other behaviour can only be shown by the bench's scenarios:
- The exact bit layouts of the status byte and of the drive-ready result byte.
- The choice between the error byte and the drive-ready layout across all four result types.
- That writes to read-only ports leave the readable state unchanged.
- The outcome when a completion and a clearing read land in the same cycle.

// File: rtl/dskc_pkg.sv
`timescale 1ns/1ps
package dskc_pkg;
  localparam int OFF_W = 3;

  localparam logic [OFF_W-1:0] OFF_STATUS = 3'd0;
  localparam logic [OFF_W-1:0] OFF_RTYPE  = 3'd1;
  localparam logic [OFF_W-1:0] OFF_ADR_HI = 3'd2;
  localparam logic [OFF_W-1:0] OFF_RBYTE  = 3'd3;
  localparam logic [OFF_W-1:0] OFF_SUBRST = 3'd7;

  typedef enum logic [1:0] {
    RT_DONE  = 2'b00,
    RT_RSV1  = 2'b01,
    RT_READY = 2'b10,
    RT_RSV3  = 2'b11
  } rtype_e;

  // Status byte: ready bits split around irq and the two presence bits.
  function automatic logic [7:0] status_pack(input logic [3:0] rdy, input logic irq);
    return {1'b0, rdy[3], rdy[2], 1'b1, 1'b1, irq, rdy[1], rdy[0]};
  endfunction

  // Drive-ready result layout: drives 1,0,3,2 in bits 7..4.
  function automatic logic [7:0] ready_pack(input logic [3:0] rdy);
    return {rdy[1], rdy[0], rdy[3], rdy[2], 4'b0000};
  endfunction

  function automatic logic [7:0] result_sel(input rtype_e rt, input logic chg,
                                            input logic [7:0] err, input logic [3:0] rdy);
    return (rt == RT_READY && chg) ? ready_pack(rdy) : err;
  endfunction
endpackage

// File: rtl/dskc_decode.sv
`timescale 1ns/1ps
module dskc_decode
  import dskc_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_PORT = 8'h78
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic              hit,
  output logic              rd_status,
  output logic              rd_rtype,
  output logic              rd_rbyte,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic              wr_subrst
);
  logic [OFF_W-1:0] off;

  assign hit = (io_addr[ADDR_W-1:OFF_W] == BASE_PORT[ADDR_W-1:OFF_W]);
  assign off = io_addr[OFF_W-1:0];

  assign rd_status = hit && io_rd && (off == OFF_STATUS);
  assign rd_rtype  = hit && io_rd && (off == OFF_RTYPE);
  assign rd_rbyte  = hit && io_rd && (off == OFF_RBYTE);
  assign wr_lo     = hit && io_wr && (off == OFF_RTYPE);
  assign wr_hi     = hit && io_wr && (off == OFF_ADR_HI);
  assign wr_subrst = hit && io_wr && (off == OFF_SUBRST);
endmodule

// File: rtl/dskc_iopb_addr.sv
`timescale 1ns/1ps
module dskc_iopb_addr #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [2*BYTE_W-1:0] addr,
  output logic              go
);
  logic [BYTE_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) hi_q <= wdata;
    end
  end

  // The high byte bypasses its register so the engine sees it with the strobe.
  assign addr = {(wr_hi ? wdata : hi_q), lo_q};
  assign go   = wr_hi;
endmodule

// File: rtl/dskc_result.sv
`timescale 1ns/1ps
module dskc_result
  import dskc_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  rtype_e           done_rtype,
  input  logic [ERR_W-1:0] done_err,
  input  logic             done_rdychg,
  input  logic             clr_irq,
  input  logic             sub_rst,
  output rtype_e           rtype_q,
  output logic [ERR_W-1:0] err_q,
  output logic             chg_q,
  output logic             irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rtype_q <= RT_DONE;
      err_q   <= '0;
      chg_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (sub_rst) begin
        rtype_q <= RT_DONE;
        err_q   <= '0;
        chg_q   <= 1'b0;
      end else if (done) begin
        rtype_q <= done_rtype;
        err_q   <= done_err;
        chg_q   <= done_rdychg;
      end
      if (done)         irq_q <= 1'b1;
      else if (clr_irq) irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dskc_host_regs.sv
`timescale 1ns/1ps
module dskc_host_regs
  import dskc_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_PORT = 8'h78
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [3:0]        drv_rdy,
  input  logic              done,
  input  logic [1:0]        done_rtype,
  input  logic [7:0]        done_err,
  input  logic              done_rdychg,
  output logic              start,
  output logic [15:0]       blk_addr,
  output logic              irq_out,
  output logic              soft_rst
);
  logic   hit, rd_status, rd_rtype, rd_rbyte, wr_lo, wr_hi, wr_subrst;
  rtype_e rtype_q;
  logic [7:0] err_q;
  logic   chg_q, irq_q;

  dskc_decode #(.ADDR_W(ADDR_W), .BASE_PORT(BASE_PORT)) u_dec (
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .hit(hit),
    .rd_status(rd_status), .rd_rtype(rd_rtype), .rd_rbyte(rd_rbyte),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_subrst(wr_subrst)
  );

  dskc_iopb_addr #(.BYTE_W(8)) u_adr (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(io_wdata), .addr(blk_addr), .go(start)
  );

  dskc_result #(.ERR_W(8)) u_res (
    .clk(clk), .rst_n(rst_n), .done(done), .done_rtype(rtype_e'(done_rtype)),
    .done_err(done_err), .done_rdychg(done_rdychg), .clr_irq(rd_rtype),
    .sub_rst(wr_subrst), .rtype_q(rtype_q), .err_q(err_q), .chg_q(chg_q),
    .irq_q(irq_q)
  );

  assign irq_out  = irq_q;
  assign soft_rst = wr_subrst;

  always_comb begin
    io_rdata = 8'h00;
    if (rd_status)     io_rdata = status_pack(drv_rdy, irq_q);
    else if (rd_rtype) io_rdata = {6'b0, rtype_q};
    else if (rd_rbyte) io_rdata = result_sel(rtype_q, chg_q, err_q, drv_rdy);
  end
endmodule

// File: rtl/dskc_host_regs_chk.sv
`timescale 1ns/1ps
module dskc_host_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              hit,
  input logic              rd_rtype,
  input logic              done,
  input logic              start,
  input logic [15:0]       blk_addr,
  input logic              irq_out,
  input logic              soft_rst,
  input logic [1:0]        rtype_q,
  input logic [7:0]        err_q
);
  a_r3_start_carries_hi: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (io_wr && blk_addr[15:8] == io_wdata));
  a_r5_done_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq_out);
  a_r4_read_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rtype && !done) |=> !irq_out);
  a_r4_rtype_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rtype |-> (io_rdata[7:2] == 6'b0));
  a_r1_status_mirrors_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && hit && io_addr[2:0] == 3'd0) |-> (io_rdata[7] == 1'b0 && io_rdata[2] == irq_out));
  a_r2_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !hit) |-> (io_rdata == 8'h00));
  a_r8_subrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rtype_q == 2'b00 && err_q == 8'h00));
  a_r8_subrst_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !done && !rd_rtype) |=> (irq_out == $past(irq_out)));
endmodule

bind dskc_host_regs dskc_host_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .hit(hit), .rd_rtype(rd_rtype),
  .done(done), .start(start), .blk_addr(blk_addr), .irq_out(irq_out),
  .soft_rst(soft_rst), .rtype_q(rtype_q), .err_q(err_q)
);

// File: tb/dskc_host_regs_tb_top.sv
`timescale 1ns/1ps
module dskc_host_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] io_addr = 8'h00;
  logic       io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic [3:0] drv_rdy = 4'b0101;
  logic       done = 1'b0;
  logic [1:0] done_rtype = 2'b00;
  logic [7:0] done_err = 8'h00;
  logic       done_rdychg = 1'b0;
  logic       start, irq_out, soft_rst;
  logic [15:0] blk_addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dskc_host_regs #(.ADDR_W(8), .BASE_PORT(8'h78)) dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .drv_rdy(drv_rdy), .done(done),
    .done_rtype(done_rtype), .done_err(done_err), .done_rdychg(done_rdychg),
    .start(start), .blk_addr(blk_addr), .irq_out(irq_out), .soft_rst(soft_rst)
  );

  // Vector: {is_write, addr, wdata, expected read data}; drives 0 and 2 ready.
  localparam int NV = 16;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h78, 8'h00, 8'h39},  // R1 status, irq clear
    {1'b0, 8'h79, 8'h00, 8'h00},  // R4 result type after reset
    {1'b0, 8'h7B, 8'h00, 8'h00},  // R6 error byte after reset
    {1'b0, 8'h7A, 8'h00, 8'h00},  // R9 write-only
    {1'b0, 8'h7C, 8'h00, 8'h00},  // R9 unused
    {1'b0, 8'h7D, 8'h00, 8'h00},  // R9 unused
    {1'b0, 8'h7E, 8'h00, 8'h00},  // R9 unused
    {1'b0, 8'h7F, 8'h00, 8'h00},  // R9 write-only
    {1'b1, 8'h78, 8'hFF, 8'h00},  // R9 write to status
    {1'b0, 8'h78, 8'h00, 8'h39},
    {1'b1, 8'h7B, 8'hAA, 8'h00},  // R9 write to result byte
    {1'b0, 8'h7B, 8'h00, 8'h00},
    {1'b0, 8'h70, 8'h00, 8'h00},  // R2 below window
    {1'b0, 8'h80, 8'h00, 8'h00},  // R2 above window
    {1'b1, 8'h82, 8'hC3, 8'h00},  // R2 write outside window
    {1'b0, 8'h79, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus access; read data sampled mid-cycle, strobes dropped after the edge.
  task automatic access(input logic wr, input logic [7:0] a, input logic [7:0] d,
                        output logic [7:0] rd);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = wr; io_rd = !wr;
    #1 rd = io_rdata;
    @(posedge clk);
    #1 io_wr = 1'b0; io_rd = 1'b0;
  endtask

  task automatic complete(input logic [1:0] rt, input logic [7:0] e, input logic chg);
    @(negedge clk);
    done = 1'b1; done_rtype = rt; done_err = e; done_rdychg = chg;
    @(posedge clk);
    #1 done = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10 reset state
    check("R10 irq", {15'b0, irq_out}, 16'h0);
    check("R10 start/soft_rst", {14'b0, start, soft_rst}, 16'h0);
    check("R10 blk_addr", blk_addr, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][24], VEC[i][23:16], VEC[i][15:8], r);
      if (!VEC[i][24]) check($sformatf("R1/R2/R9 vector %0d", i), {8'h0, r}, {8'h0, VEC[i][7:0]});
    end

    // R3 address assembly and start strobe
    access(1'b1, 8'h79, 8'h34, r);
    check("R3 no start on low write", {15'b0, start}, 16'h0);
    @(negedge clk);
    io_addr = 8'h7A; io_wdata = 8'h12; io_wr = 1'b1;
    #1 check("R3 start during hi write", {15'b0, start}, 16'h1);
    check("R3 addr during hi write", blk_addr, 16'h1234);
    @(posedge clk); #1 io_wr = 1'b0;
    @(negedge clk);
    check("R3 start drops", {15'b0, start}, 16'h0);
    check("R3 addr held", blk_addr, 16'h1234);

    // R5 completion with error, R6 error byte, R1 irq in status
    complete(2'b00, 8'h0A, 1'b0);
    check("R5 irq set", {15'b0, irq_out}, 16'h1);
    access(1'b0, 8'h78, 8'h00, r);
    check("R1 status with irq", {8'h0, r}, 16'h003D);
    access(1'b0, 8'h7B, 8'h00, r);
    check("R6 error byte", {8'h0, r}, 16'h000A);
    // R4 read clears irq
    access(1'b0, 8'h79, 8'h00, r);
    check("R4 rtype value", {8'h0, r}, 16'h0000);
    check("R4 irq cleared", {15'b0, irq_out}, 16'h0);
    access(1'b0, 8'h78, 8'h00, r);
    check("R4 status bit2 cleared", {8'h0, r}, 16'h0039);

    // R7 ready layout: rdy=0101 -> 0x50
    complete(2'b10, 8'h80, 1'b1);
    access(1'b0, 8'h7B, 8'h00, r);
    check("R7 ready layout", {8'h0, r}, 16'h0050);
    drv_rdy = 4'b1010;
    access(1'b0, 8'h7B, 8'h00, r);
    check("R7 ready layout live", {8'h0, r}, 16'h00A0);
    drv_rdy = 4'b0101;
    access(1'b0, 8'h79, 8'h00, r);
    check("R4 rtype 10", {8'h0, r}, 16'h0002);
    complete(2'b10, 8'h80, 1'b0);
    access(1'b0, 8'h7B, 8'h00, r);
    check("R7 type 10 without flag", {8'h0, r}, 16'h0080);
    complete(2'b01, 8'h21, 1'b1);
    access(1'b0, 8'h7B, 8'h00, r);
    check("R7 reserved 01", {8'h0, r}, 16'h0021);
    complete(2'b11, 8'h12, 1'b1);
    access(1'b0, 8'h7B, 8'h00, r);
    check("R7 reserved 11", {8'h0, r}, 16'h0012);

    // R5 completion racing a clearing read
    @(negedge clk);
    io_addr = 8'h79; io_rd = 1'b1;
    done = 1'b1; done_rtype = 2'b00; done_err = 8'h44; done_rdychg = 1'b0;
    #1 check("R5 race read old type", {8'h0, io_rdata}, 16'h0003);
    @(posedge clk); #1 io_rd = 1'b0; done = 1'b0;
    check("R5 set wins over clear", {15'b0, irq_out}, 16'h1);

    // R8 subsystem reset
    @(negedge clk);
    io_addr = 8'h7F; io_wr = 1'b1;
    #1 check("R8 soft_rst pulse", {15'b0, soft_rst}, 16'h1);
    @(posedge clk); #1 io_wr = 1'b0;
    @(negedge clk);
    check("R8 soft_rst drops", {15'b0, soft_rst}, 16'h0);
    check("R8 irq kept", {15'b0, irq_out}, 16'h1);
    access(1'b0, 8'h7B, 8'h00, r);
    check("R8 error cleared", {8'h0, r}, 16'h0000);
    access(1'b0, 8'h79, 8'h00, r);
    check("R8 type 00", {8'h0, r}, 16'h0000);

    // R8 reset beats completion
    @(negedge clk);
    io_addr = 8'h7F; io_wr = 1'b1;
    done = 1'b1; done_rtype = 2'b10; done_err = 8'h55; done_rdychg = 1'b1;
    @(posedge clk); #1 io_wr = 1'b0; done = 1'b0;
    access(1'b0, 8'h7B, 8'h00, r);
    check("R8 reset wins error byte", {8'h0, r}, 16'h0000);
    access(1'b0, 8'h79, 8'h00, r);
    check("R8 reset wins type", {8'h0, r}, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule